// File: doc/BRIEF.md
# Block-Float to Fixed-Point Output Scaler

This block sits on the result stream of a transform engine that produces its output in block-floating-point form. That form is one unsigned exponent shared by the whole block, plus a signed real and imaginary mantissa for each sample. The scaler turns each mantissa pair into a plain fixed-point value while the samples stream past. The caller picks a target scale. When the engine raises its done strobe, the scaler captures that scale together with the block exponent. Each later sample is shifted by the difference between the two, so all output blocks share one fixed-point weighting.

A target above the exponent makes the mantissas smaller: they shift right, with round-to-nearest. A target below the exponent makes them larger: they shift left. A left shift that no longer fits the output width is clamped to the nearest 16-bit limit. Such a sample is flagged on its own, without marking the rest of the block. The data, the strobe and the flag all pass through one register stage.

Top module: `bfp_out_scaler`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_ovf`, `out_re` and `out_im` are 0, and the captured scale and exponent are both 0, so scaling is a pass-through after reset.
- R2: On a clock edge with `done_i` high, `scale_i` and `exp_i` are captured. The captured pair applies to samples presented from the next cycle on. A sample presented in the same cycle as `done_i` still uses the previous pair.
- R3: When the captured scale equals the captured exponent, each valid sample leaves unchanged and `out_ovf` stays low.
- R4: When scale exceeds exponent by k, each lane becomes floor((x + 2^(k-1)) / 2^k), which is round-to-nearest with ties toward plus infinity. The result is clamped to 32767, and `out_ovf` stays low.
- R5: When exponent exceeds scale by k, each lane becomes x·2^k whenever that value lies in -32768..32767.
- R6: When a left-shifted lane lies above 32767 it becomes 32767, and when it lies below -32768 it becomes -32768. Real and imaginary lanes saturate independently.
- R7: `out_ovf` is high exactly for an output sample in which at least one lane saturated. It is low whenever `out_valid` is low.
- R8: `out_valid` equals `in_valid` delayed by one clock. The output data and flag belong to the sample presented one cycle earlier.
- R9: Changes to `scale_i` or `exp_i` while `done_i` is low have no effect on the scaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Transform-complete strobe; captures scale and exponent |
| scale_i | input | 4 | Requested output scale, unsigned |
| exp_i | input | 4 | Block exponent, unsigned |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 16 | Real mantissa, two's complement |
| in_im | input | 16 | Imaginary mantissa, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | 16 | Scaled real value |
| out_im | output | 16 | Scaled imaginary value |
| out_ovf | output | 1 | Saturation flag for this sample |

## Verification
The bench targets the boundaries of the shift distance: zero, one bit and fifteen bits in each direction. At these points a sign error in the difference, or an off-by-one in the amount, shows up as a doubled or halved value. Rounding ties such as ±16 shifted by 5 expose a design that truncates or rounds toward zero, because it returns a value one lower on positive ties. Samples with only one lane out of range catch a design that saturates both lanes together, or one that leaves the flag raised on idle cycles. A sample sent in the same cycle as `done_i`, and settings changed without `done_i`, catch a design that reads the scale combinationally instead of from the captured pair.

// File: rtl/bfp_scale_pkg.sv
package bfp_scale_pkg;
   typedef enum logic [1:0] {
      SH_NONE  = 2'd0,
      SH_RIGHT = 2'd1,
      SH_LEFT  = 2'd2
   } shift_dir_e;

   localparam int unsigned LANES = 2;
endpackage

// File: rtl/bfp_scale_setting.sv
module bfp_scale_setting
   import bfp_scale_pkg::*;
#(
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [EXP_W-1:0] scale_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic [EXP_W-1:0] scale_q,
   output logic [EXP_W-1:0] exp_q,
   output shift_dir_e       dir,
   output logic [EXP_W-1:0] amt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q <= '0;
         exp_q   <= '0;
      end else if (done_i) begin
         scale_q <= scale_i;
         exp_q   <= exp_i;
      end
   end

   always_comb begin
      if (scale_q > exp_q) begin
         dir = SH_RIGHT;
         amt = scale_q - exp_q;
      end else if (scale_q < exp_q) begin
         dir = SH_LEFT;
         amt = exp_q - scale_q;
      end else begin
         dir = SH_NONE;
         amt = '0;
      end
   end
endmodule

// File: rtl/bfp_lane_shift.sv
module bfp_lane_shift
   import bfp_scale_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int EXP_W      = 4,
   parameter bit ROUND_NEAR = 1'b1
) (
   input  logic signed [DATA_W-1:0] x,
   input  shift_dir_e               dir,
   input  logic [EXP_W-1:0]         amt,
   output logic signed [DATA_W-1:0] y,
   output logic                     sat
);
   localparam int MAXSH = (1 << EXP_W) - 1;
   localparam int WW    = DATA_W + MAXSH + 1;
   localparam logic signed [WW-1:0] LIM_HI =
      {{(WW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [WW-1:0] LIM_LO = ~LIM_HI;

   logic signed [WW-1:0] ext;
   logic signed [WW-1:0] bias;
   logic signed [WW-1:0] work;

   assign ext = WW'(x);

   generate
      if (ROUND_NEAR) begin : g_round
         assign bias = (amt == '0) ? '0 : (WW'(1) <<< (amt - 1'b1));
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   always_comb begin
      case (dir)
         SH_RIGHT: work = (ext + bias) >>> amt;
         SH_LEFT:  work = ext <<< amt;
         default:  work = ext;
      endcase
      sat = 1'b0;
      if (work > LIM_HI) begin
         y   = LIM_HI[DATA_W-1:0];
         sat = 1'b1;
      end else if (work < LIM_LO) begin
         y   = LIM_LO[DATA_W-1:0];
         sat = 1'b1;
      end else begin
         y = work[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/bfp_out_scaler.sv
module bfp_out_scaler
   import bfp_scale_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int EXP_W      = 4,
   parameter bit ROUND_NEAR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     done_i,
   input  logic [EXP_W-1:0]         scale_i,
   input  logic [EXP_W-1:0]         exp_i,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_re,
   output logic signed [DATA_W-1:0] out_im,
   output logic                     out_ovf
);
   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("bfp_out_scaler: DATA_W must be at least 2");
      end
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp_w
         $error("bfp_out_scaler: EXP_W must lie in 1..5");
      end
   endgenerate

   logic [EXP_W-1:0] set_scale;
   logic [EXP_W-1:0] set_exp;
   shift_dir_e       sh_dir;
   logic [EXP_W-1:0] sh_amt;

   bfp_scale_setting #(.EXP_W(EXP_W)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_i  (done_i),
      .scale_i (scale_i),
      .exp_i   (exp_i),
      .scale_q (set_scale),
      .exp_q   (set_exp),
      .dir     (sh_dir),
      .amt     (sh_amt)
   );

   logic signed [DATA_W-1:0] lane_x [LANES];
   logic signed [DATA_W-1:0] lane_y [LANES];
   logic [LANES-1:0]         lane_sat;

   assign lane_x[0] = in_re;
   assign lane_x[1] = in_im;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         bfp_lane_shift #(
            .DATA_W     (DATA_W),
            .EXP_W      (EXP_W),
            .ROUND_NEAR (ROUND_NEAR)
         ) u_shift (
            .x   (lane_x[g]),
            .dir (sh_dir),
            .amt (sh_amt),
            .y   (lane_y[g]),
            .sat (lane_sat[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_re  <= lane_y[0];
            out_im  <= lane_y[1];
            out_ovf <= |lane_sat;
         end else begin
            out_ovf <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bfp_scale_chk.sv
module bfp_scale_chk #(
   parameter int DATA_W = 16,
   parameter int EXP_W  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     done_i,
   input logic [EXP_W-1:0]         scale_i,
   input logic [EXP_W-1:0]         exp_i,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] in_re,
   input logic signed [DATA_W-1:0] in_im,
   input logic [EXP_W-1:0]         set_scale,
   input logic [EXP_W-1:0]         set_exp,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_re,
   input logic signed [DATA_W-1:0] out_im,
   input logic                     out_ovf
);
   localparam logic signed [DATA_W-1:0] VMAX = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] VMIN = {1'b1, {(DATA_W-1){1'b0}}};

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (set_scale == $past(scale_i)) && (set_exp == $past(exp_i)));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(set_scale) && $stable(set_exp));

   p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && set_scale == set_exp) |=>
         (out_re == $past(in_re)) && (out_im == $past(in_im)) && !out_ovf);

   p_right_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && set_scale > set_exp) |=> !out_ovf);

   p_sat_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_re == VMAX || out_re == VMIN ||
                   out_im == VMAX || out_im == VMIN));

   p_ovf_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_valid);

   p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
endmodule

bind bfp_out_scaler bfp_scale_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/sim_bfp_out_scaler.sv
module sim_bfp_out_scaler;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              done_i = 1'b0;
   logic [3:0]        scale_i = '0;
   logic [3:0]        exp_i = '0;
   logic              in_valid = 1'b0;
   logic signed [15:0] in_re = '0;
   logic signed [15:0] in_im = '0;
   logic              out_valid;
   logic signed [15:0] out_re;
   logic signed [15:0] out_im;
   logic              out_ovf;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   string phase = "R3";

   always #10 clk = ~clk;

   bfp_out_scaler u0 (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .scale_i(scale_i),
      .exp_i(exp_i), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
      .out_ovf(out_ovf)
   );

   function automatic void chk(bit ok, string req, int act, int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endfunction

   function automatic void ref_lane(input int x, input int s, input int e,
                                    output int y, output bit sat);
      longint v;
      if (s > e)      v = (longint'(x) + (longint'(1) << (s - e - 1))) >>> (s - e);
      else if (s < e) v = longint'(x) << (e - s);
      else            v = longint'(x);
      sat = 1'b0;
      if (v > 32767)       begin v = 32767;  sat = 1'b1; end
      else if (v < -32768) begin v = -32768; sat = 1'b1; end
      y = int'(v);
   endfunction

   // Reference model state
   int    m_scale = 0, m_exp = 0;
   bit    m_valid = 0, m_ovf = 0;
   int    m_re = 0, m_im = 0;
   string m_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_scale <= 0; m_exp <= 0; m_valid <= 0; m_ovf <= 0;
         m_re <= 0; m_im <= 0; m_tag <= "R1";
      end else begin
         int yr, yi;
         bit sr, si;
         m_valid <= in_valid;
         if (in_valid) begin
            ref_lane(int'(in_re), m_scale, m_exp, yr, sr);
            ref_lane(int'(in_im), m_scale, m_exp, yi, si);
            m_re  <= yr;
            m_im  <= yi;
            m_ovf <= sr | si;
            if (sr | si)              m_tag <= "R6";
            else if (m_scale > m_exp) m_tag <= "R4";
            else if (m_scale < m_exp) m_tag <= "R5";
            else                      m_tag <= "R3";
         end else begin
            m_ovf <= 0;
         end
         if (done_i) begin
            m_scale <= int'(scale_i);
            m_exp   <= int'(exp_i);
         end
      end
   end

   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         chk(out_valid == m_valid, {"R8/", phase}, int'(out_valid), int'(m_valid));
         chk(out_ovf == m_ovf, {"R7/", phase}, int'(out_ovf), int'(m_ovf));
         if (m_valid) begin
            chk(int'(out_re) == m_re, {m_tag, "/", phase, " re"}, int'(out_re), m_re);
            chk(int'(out_im) == m_im, {m_tag, "/", phase, " im"}, int'(out_im), m_im);
         end
      end
   end

   task automatic setcfg(int s, int e);
      @(negedge clk);
      done_i = 1'b1; scale_i = 4'(s); exp_i = 4'(e); in_valid = 1'b0;
      @(negedge clk);
      done_i = 1'b0;
   endtask

   task automatic send(int re, int im);
      @(negedge clk);
      in_valid = 1'b1; in_re = 16'(re); in_im = 16'(im);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic burst(int n);
      for (int i = 0; i < n; i++) send(int'($signed(16'($urandom))), int'($signed(16'($urandom))));
      idle(1);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
      chk(out_ovf == 1'b0, "R1 ovf", int'(out_ovf), 0);
      chk(out_re == 16'sd0, "R1 re", int'(out_re), 0);
      chk(out_im == 16'sd0, "R1 im", int'(out_im), 0);
      @(negedge clk); rst_n = 1'b1;

      phase = "R1"; send(1234, -4321); send(-32768, 32767); idle(1);
      phase = "R3"; setcfg(5, 5); send(-32768, 32767); send(0, -1); burst(8);
      phase = "R4"; setcfg(8, 3);
      send(16, -16); send(48, -48); send(15, -17); send(32767, -32768); burst(8);
      setcfg(1, 0); send(1, -1); send(3, -3); send(32767, -32768); idle(1);
      setcfg(15, 0); send(32767, -32768); send(16384, -16385); burst(4);
      phase = "R5"; setcfg(2, 6); send(2047, -2048); send(-1, 1); idle(1);
      phase = "R6"; send(2048, 5); send(-7, -2049); send(30000, -30000); burst(8);
      setcfg(0, 15); send(0, 1); send(-1, 0); send(0, 0); idle(1);
      setcfg(3, 4); send(16383, -16384); send(16384, -16385); idle(2);
      phase = "R2"; setcfg(4, 4);
      @(negedge clk);
      done_i = 1'b1; scale_i = 4'd2; exp_i = 4'd7;
      in_valid = 1'b1; in_re = 16'sd100; in_im = -16'sd100;
      @(negedge clk);
      done_i = 1'b0; in_re = 16'sd100; in_im = -16'sd100;
      idle(1);
      phase = "R9"; scale_i = 4'd15; exp_i = 4'd0;
      send(100, -100); send(2000, 1); scale_i = 4'd0; exp_i = 4'd15;
      send(-3, 3); idle(2);
      phase = "R8";
      for (int i = 0; i < 40; i++) begin
         if (i % 3 == 0) idle(1);
         else send(int'($signed(16'($urandom))), int'($signed(16'($urandom))));
      end
      idle(3);
      finish_run();
   end
endmodule